// File: doc/BRIEF.md
# Write-Busy Status Readback and Write Qualifier

This block sits between a byte-wide nonvolatile memory array and its host-side strobes. While the internal programming period is running, it decides what a read returns. The value is built so that the host can find out when the write has finished in either of two ways. Bit 7 reads as the inverse of the last written byte's bit 7 when the host reads that byte's address. Bit 6 flips on every new read access. Once the busy flag drops, reads return plain array data.

The block also decides whether a write strobe counts. A write counts only when chip enable and write enable are both low and output enable is high. The strobe must have been held for a minimum number of clock cycles. Power must have been good for a lockout delay measured in clock cycles. An accepted write is reported as a single-cycle pulse when the strobe is released. All strobes are active-low and synchronous to `clk`. The storage array and the page buffer live outside this block.

Top module: `prog_busy_status`

## Requirements
- R1: In reset and on the first cycle after it, `rd_data` is 0, `wr_go` is 0, and the toggle state starts at 0.
- R2: A read access is `ce_n`=0 with `oe_n`=0. When the inputs sampled at a clock edge show no read access, `rd_data` is 0 after that edge.
- R3: While `busy` is 0, a read access sampled at an edge makes `rd_data` equal `arr_data` from that same edge, after that edge.
- R4: While `busy` is 1, the read byte carries `arr_data` in bits 5:0. Bit 7 is the inverse of `last_data[7]` when `rd_addr` equals `last_addr`, and is `arr_data[7]` otherwise.
- R5: While `busy` is 1, bit 6 of the read byte shows the toggle state. The toggle state inverts at the edge where a read access is first seen after a cycle without one, and holds for the rest of that access.
- R6: While `busy` is 0, the toggle state does not change and bit 6 shows `arr_data[6]`. A later busy period continues from the held toggle value.
- R7: A write strobe is active only when `ce_n`=0, `we_n`=0 and `oe_n`=1. Any other combination inhibits the write, including output enable low.
- R8: `wr_go` pulses high for exactly one cycle, after the first edge at which the write strobe is seen inactive. It pulses only if the strobe was seen active on at least `MIN_PULSE` consecutive edges just before.
- R9: A write is accepted only if `pwr_good` was sampled high on at least `LOCK_CYC` consecutive edges before the release edge. A low `pwr_good` restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Supply is within range |
| busy | input | 1 | Internal programming period active |
| last_addr | input | ADDR_W | Address of the last byte loaded for programming |
| last_data | input | 8 | Value of the last byte loaded for programming |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_addr | input | ADDR_W | Address of the current read |
| arr_data | input | 8 | Array content at `rd_addr` |
| rd_data | output | 8 | Registered read byte |
| wr_go | output | 1 | One-cycle pulse for an accepted write |

## Verification
Most internal errors reach `rd_data` or `wr_go` within one edge. The exception is a toggle state that flipped at the wrong time: it stays hidden until the next read access during a busy period, and then shows as a wrong bit 6 on every later access. A power timer or pulse-width counter that is off by one shows only at the boundary release, which is one cycle short of or exactly at the limit. Directed cases place releases at both sides of each limit. Long random runs with accesses opening and closing while busy rises and falls catch a drifting toggle phase.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

   localparam int unsigned DATA_W     = 8;
   localparam int unsigned POLL_BIT   = 7;
   localparam int unsigned TOGGLE_BIT = 6;

   typedef logic [DATA_W-1:0] byte_t;

   // Byte presented while programming is in progress
   function automatic byte_t busy_view(input byte_t arr, input logic addr_hit,
                                       input byte_t last, input logic tog);
      byte_t r;
      r             = arr;
      r[TOGGLE_BIT] = tog;
      if (addr_hit) r[POLL_BIT] = ~last[POLL_BIT];
      return r;
   endfunction

endpackage

// File: rtl/pbs_power_lock.sv
module pbs_power_lock #(
   parameter int unsigned LOCK_CYC = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   output logic unlocked
);
   localparam int unsigned CW = $clog2(LOCK_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYC);

   initial begin : p_param_chk
      assert (LOCK_CYC >= 1) else $fatal(1, "LOCK_CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!pwr_good)     cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign unlocked = (cnt_q == LIMIT);

   // R9: a supply drop re-arms the lockout at once
   a_r9_drop_relocks: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> !unlocked);

endmodule

// File: rtl/pbs_strobe_qual.sv
module pbs_strobe_qual #(
   parameter int unsigned MIN_PULSE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   input  logic unlocked,
   output logic wr_go
);
   initial begin : p_param_chk
      assert (MIN_PULSE >= 1) else $fatal(1, "MIN_PULSE must be at least 1");
   end

   logic wr_act;
   logic held_ok;
   logic go_q;

   // R7: output enable low, chip enable high or write enable high inhibit
   assign wr_act = !ce_n && !we_n && oe_n;

   generate
      if (MIN_PULSE == 1) begin : g_direct
         logic act_q;
         always_ff @(posedge clk) begin
            if (!rst_n) act_q <= 1'b0;
            else        act_q <= wr_act;
         end
         assign held_ok = act_q;
      end else begin : g_count
         localparam int unsigned CW = $clog2(MIN_PULSE + 1);
         localparam logic [CW-1:0] LIMIT = CW'(MIN_PULSE);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)              cnt_q <= '0;
            else if (!wr_act)        cnt_q <= '0;
            else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
         end
         assign held_ok = (cnt_q == LIMIT);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) go_q <= 1'b0;
      else        go_q <= !wr_act && held_ok && unlocked;
   end

   assign wr_go = go_q;

   // R8: an accepted write is a single-cycle pulse
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go |=> !wr_go);

endmodule

// File: rtl/pbs_read_mux.sv
module pbs_read_mux
   import pbs_pkg::*;
#(
   parameter int unsigned ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              busy,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [ADDR_W-1:0] last_addr,
   input  byte_t             last_data,
   input  byte_t             arr_data,
   output byte_t             rd_data
);
   initial begin : p_param_chk
      assert (ADDR_W >= 1) else $fatal(1, "ADDR_W must be at least 1");
   end

   logic  rd_act, rd_act_q, rd_start;
   logic  tog_q, tog_nxt;
   logic  addr_hit;
   byte_t view;
   byte_t rd_q;

   assign rd_act   = !ce_n && !oe_n;
   assign rd_start = rd_act && !rd_act_q;
   assign addr_hit = (rd_addr == last_addr);
   assign tog_nxt  = (rd_start && busy) ? ~tog_q : tog_q;
   assign view     = busy ? busy_view(arr_data, addr_hit, last_data, tog_nxt) : arr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_act_q <= 1'b0;
         tog_q    <= 1'b0;
         rd_q     <= '0;
      end else begin
         rd_act_q <= rd_act;
         tog_q    <= tog_nxt;
         rd_q     <= rd_act ? view : '0;
      end
   end

   assign rd_data = rd_q;

   // R2: no access drives an all-zero byte
   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_act |=> (rd_data == '0));

   // R3: idle programming passes array data
   a_r3_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && !busy) |=> (rd_data == $past(arr_data)));

   // R4: polled bit is inverted on the last written address
   a_r4_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && busy && addr_hit) |=> (rd_data[POLL_BIT] == !$past(last_data[POLL_BIT])));

   // R5: a fresh access while busy presents the flipped toggle
   a_r5_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && busy) |=> (rd_data[TOGGLE_BIT] != $past(tog_q)));

endmodule

// File: rtl/prog_busy_status.sv
module prog_busy_status
   import pbs_pkg::*;
#(
   parameter int unsigned ADDR_W    = 17,
   parameter int unsigned LOCK_CYC  = 250000,
   parameter int unsigned MIN_PULSE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_good,
   input  logic              busy,
   input  logic [ADDR_W-1:0] last_addr,
   input  logic [7:0]        last_data,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        arr_data,
   output logic [7:0]        rd_data,
   output logic              wr_go
);
   initial begin : p_param_chk
      assert (DATA_W == 8) else $fatal(1, "byte width must be 8");
   end

   logic unlocked;

   pbs_power_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_good (pwr_good),
      .unlocked (unlocked)
   );

   pbs_strobe_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .we_n     (we_n),
      .unlocked (unlocked),
      .wr_go    (wr_go)
   );

   pbs_read_mux #(.ADDR_W(ADDR_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_n      (ce_n),
      .oe_n      (oe_n),
      .busy      (busy),
      .rd_addr   (rd_addr),
      .last_addr (last_addr),
      .last_data (last_data),
      .arr_data  (arr_data),
      .rd_data   (rd_data)
   );

   // R9: every accepted write was decided while the lockout had expired
   a_r9_lock_gate: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go |-> $past(unlocked));

endmodule

// File: tb/prog_busy_status_bench.sv
module prog_busy_status_bench;
   localparam int AW   = 8;
   localparam int LOCK = 40;
   localparam int MINP = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n, pwr_good, busy, ce_n, oe_n, we_n;
   logic [AW-1:0] rd_addr, last_addr;
   logic [7:0]    last_data, arr_data;
   wire  [7:0]    rd_data;
   wire           wr_go;

   prog_busy_status #(.ADDR_W(AW), .LOCK_CYC(LOCK), .MIN_PULSE(MINP)) u_prog_busy_status (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .busy(busy),
      .last_addr(last_addr), .last_data(last_data), .ce_n(ce_n), .oe_n(oe_n),
      .we_n(we_n), .rd_addr(rd_addr), .arr_data(arr_data),
      .rd_data(rd_data), .wr_go(wr_go)
   );

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;

   // bench model state
   bit       m_tog, m_prev_rd;
   int       m_wcnt, m_lcnt;
   bit [7:0] exp_rd;
   bit       exp_go;

   task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic bit [7:0] model_view(bit rd, bit bsy, bit hit, bit [7:0] arr, bit [7:0] last, bit tog);
      bit [7:0] r;
      if (!rd) return 8'h00;
      r = arr;
      if (bsy) begin
         r[6] = tog;
         if (hit) r[7] = ~last[7];
      end
      return r;
   endfunction

   task automatic step();
      bit rd, wr, start, unl;
      string rtag, gtag;
      @(posedge clk);
      rd    = !ce_n && !oe_n;
      start = rd && !m_prev_rd;
      if (start && busy) m_tog = ~m_tog;
      exp_rd = model_view(rd, busy, rd_addr == last_addr, arr_data, last_data, m_tog);
      m_prev_rd = rd;
      wr     = !ce_n && !we_n && oe_n;
      unl    = (m_lcnt == LOCK);
      exp_go = !wr && (m_wcnt >= MINP) && unl;
      m_wcnt = wr ? ((m_wcnt < MINP) ? m_wcnt + 1 : MINP) : 0;
      m_lcnt = pwr_good ? ((m_lcnt < LOCK) ? m_lcnt + 1 : LOCK) : 0;
      if (!rd)       rtag = "R2";
      else if (!busy) rtag = "R3";
      else if (rd_addr == last_addr) rtag = "R4";
      else           rtag = "R5";
      gtag = unl ? "R8" : "R9";
      @(negedge clk);
      chk(rtag, "rd_data", rd_data, exp_rd);
      chk(gtag, "wr_go", {7'd0, wr_go}, {7'd0, exp_go});
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic idle();
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic wr_pulse(input int n);
      ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
      run(n);
      idle();
      step();
   endtask

   task automatic finish_up();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_up();
      end
   end

   initial begin
      bit [7:0] b1, b2, b3;
      int seed;
      seed = $urandom(32'h5eed_0101);
      rst_n = 1'b0; pwr_good = 1'b0; busy = 1'b0; idle();
      rd_addr = '0; last_addr = 8'h12; last_data = 8'h80; arr_data = 8'h00;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "rd_data in reset", rd_data, 8'h00);
      chk("R1", "wr_go in reset", {7'd0, wr_go}, 8'h00);
      rst_n = 1'b1;
      m_tog = 0; m_prev_rd = 0; m_wcnt = 0; m_lcnt = 0;
      step();
      chk("R1", "rd_data after reset", rd_data, 8'h00);

      // R9: locked while power not good
      wr_pulse(5);
      chk("R9", "wr_go with power low", {7'd0, wr_go}, 8'h00);
      // release one cycle short of the lockout
      pwr_good = 1'b1;
      wr_pulse(LOCK - 1);
      chk("R9", "wr_go one short of lockout", {7'd0, wr_go}, 8'h00);
      pwr_good = 1'b0; step(); pwr_good = 1'b1;
      wr_pulse(LOCK);
      chk("R9", "wr_go at lockout", {7'd0, wr_go}, 8'h01);
      step();
      chk("R8", "wr_go one cycle only", {7'd0, wr_go}, 8'h00);

      // R8: pulse width limit
      wr_pulse(MINP - 1);
      chk("R8", "short strobe", {7'd0, wr_go}, 8'h00);
      wr_pulse(MINP);
      chk("R8", "minimum strobe", {7'd0, wr_go}, 8'h01);

      // R7: inhibit combinations
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; run(5); idle(); step();
      chk("R7", "oe low inhibits", {7'd0, wr_go}, 8'h00);
      ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b1; run(5); idle(); step();
      chk("R7", "ce high inhibits", {7'd0, wr_go}, 8'h00);

      // R3: pass-through when idle
      busy = 1'b0; rd_addr = 8'h12; arr_data = 8'hC3; ce_n = 1'b0; oe_n = 1'b0;
      step();
      chk("R3", "idle read", rd_data, 8'hC3);
      idle(); step();
      chk("R2", "no access", rd_data, 8'h00);
      ce_n = 1'b1; oe_n = 1'b0; step();
      chk("R2", "ce high", rd_data, 8'h00);

      // R4: polling on last address
      busy = 1'b1; arr_data = 8'h80; rd_addr = 8'h12; ce_n = 1'b0; oe_n = 1'b0;
      step();
      chk("R4", "poll bit7 on hit", {7'd0, rd_data[7]}, 8'h00);
      rd_addr = 8'h34; step();
      chk("R4", "bit7 on miss", {7'd0, rd_data[7]}, 8'h01);

      // R5: toggle across accesses, steady within one
      b1 = rd_data; step();
      chk("R5", "bit6 steady in access", {7'd0, rd_data[6]}, {7'd0, b1[6]});
      oe_n = 1'b1; step(); oe_n = 1'b0; step(); b2 = rd_data;
      chk("R5", "bit6 flips", {7'd0, b2[6]}, {7'd0, ~b1[6]});
      ce_n = 1'b1; step(); ce_n = 1'b0; step(); b3 = rd_data;
      chk("R5", "bit6 flips again", {7'd0, b3[6]}, {7'd0, b1[6]});

      // R6: frozen toggle while idle
      busy = 1'b0; arr_data = 8'h40; oe_n = 1'b1; step(); oe_n = 1'b0; step();
      chk("R6", "bit6 from array", {7'd0, rd_data[6]}, 8'h01);
      arr_data = 8'h00; oe_n = 1'b1; step(); oe_n = 1'b0; step();
      chk("R6", "bit6 from array low", {7'd0, rd_data[6]}, 8'h00);
      busy = 1'b1; oe_n = 1'b1; step(); oe_n = 1'b0; step();
      chk("R6", "toggle resumes from held", {7'd0, rd_data[6]}, {7'd0, ~b3[6]});
      idle(); busy = 1'b0; step();

      // random phase
      for (int i = 0; i < 6000; i++) begin
         int r;
         r = $urandom % 16;
         if (r < 3) ce_n = ~ce_n;
         else if (r < 6) oe_n = ~oe_n;
         else if (r < 8) we_n = ~we_n;
         if ($urandom % 64 == 0) begin
            busy = ~busy;
            if (busy) begin
               last_addr = AW'($urandom);
               last_data = 8'($urandom);
            end
         end
         if ($urandom % 400 == 0) pwr_good = 1'b0;
         else if ($urandom % 8 == 0) pwr_good = 1'b1;
         rd_addr  = ($urandom % 2) ? last_addr : AW'($urandom);
         arr_data = 8'($urandom);
         step();
      end

      finish_up();
   end
endmodule